// File: doc/BRIEF.md
# ISA Bus Sizing Cycle Controller

This block sits on the host side of an ISA-style expansion bus and turns one 16-bit processor request into bus cycles. A request supplies a word address, write data, a read/write flag and a memory/IO flag, qualified by a one-clock strobe. The controller runs each transfer through a fixed sequence: an address phase that pulses the address latch enable, a command phase lasting a configurable number of bus clocks, and one idle bus clock. All phases advance on a bus clock derived inside the block with a 50 percent duty cycle.

During the address phase of the first transfer the target answers on an active-low wide-capable line. A target that answers is served in one 16-bit transfer. A target that stays silent is treated as byte-wide, and the access is split into two byte transfers. The second transfer repeats the address with bit 0 set, moves the high byte onto the low data lanes, releases the high-lane enable and does not pulse the address latch enable. For reads, the two bytes are joined into one word before the one-clock done pulse. The address latch enable output is the OR of the internal latch pulse and the hold acknowledge of a DMA or refresh grant.

Top module: `isa_sizer`

## Requirements
- R1: When `wide_ack_n` is low during the address phase, the access uses one command strobe. When it is high, the access uses exactly two command strobes.
- R2: The first transfer drives `bus_addr` = {`req_waddr`, 0}. The second transfer of a split access drives {`req_waddr`, 1}.
- R3: On a write, `lane_oe` is high only while a write strobe is low. The first transfer drives the whole word on `lane_out`. The second transfer drives {8'h00, high byte}.
- R4: For a 16-bit target, `rdata` equals the 16-bit `lane_in` word. For a byte target, `rdata` = {low lane of the second transfer, low lane of the first transfer}, and the upper lane of the first transfer is ignored. `done` is high for exactly one clock after the last transfer.
- R5: With `hold_ack` low, `addr_latch` rises exactly once per access, during the address phase of the first transfer only.
- R6: `hi_lane_n` is low throughout the first transfer and high during the second transfer of a split access. It is high when the block is idle.
- R7: While `hold_ack` is high, `addr_latch` is high.
- R8: `bus_addr` does not change while a command strobe is low.
- R9: The request flags pick the strobe as follows: memory read gives `mem_rd_n`, memory write gives `mem_wr_n`, IO read gives `io_rd_n`, and IO write gives `io_wr_n`. No more than one strobe is low at a time, and all are high in reset.
- R10: `bclk` is high for HALF_DIV clocks and low for HALF_DIV clocks. Each command strobe stays low for exactly CMD_CLKS × 2 × HALF_DIV clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-clock request strobe, taken when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = IO space, 0 = memory space |
| req_waddr | input | ADDR_W-1 | Word address (bus address bits above bit 0) |
| req_wdata | input | 16 | Write data word |
| rdata | output | 16 | Assembled read word, valid with done |
| done | output | 1 | One-clock completion pulse |
| bclk | output | 1 | Bus clock, 50 percent duty |
| addr_latch | output | 1 | Address latch enable (internal pulse OR hold_ack) |
| bus_addr | output | ADDR_W | Bus address |
| hi_lane_n | output | 1 | Active-low: upper data lanes valid |
| lane_out | output | 16 | Data lanes driven for writes |
| lane_oe | output | 1 | Output enable for lane_out |
| lane_in | input | 16 | Data lanes returned by target |
| wide_ack_n | input | 1 | Active-low: target accepts 16-bit transfer |
| hold_ack | input | 1 | DMA/refresh grant acknowledge |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| io_rd_n | output | 1 | IO read strobe |
| io_wr_n | output | 1 | IO write strobe |

## Verification
The assertions check these rules on every cycle:
- the address is held steady under an active strobe;
- the high-lane enable agrees with address bit 0 during commands;
- the latch enable follows the hold acknowledge and never appears on a second transfer;
- at most one strobe is low at a time;
- the output enable is tied to write strobes;
- done is a single-clock pulse.

Only the bench scenarios can show that the number of transfers follows the sampled width. The same holds for the bytes on the lanes matching the request word and the read word being assembled correctly. The strobe widths and the bus clock duty also depend on the scenarios. The bench shows these by sweeping address, direction, space and target width.

// File: rtl/isa_sizer_pkg.sv
// Shared types for the bus sizing controller.
// Assumes: one phase encoding shared by the cycle sequencer and the checker.
package isa_sizer_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_WAIT = 3'd1,
        PH_ADDR = 3'd2,
        PH_CMD  = 3'd3,
        PH_GAP  = 3'd4
    } phase_t;
endpackage

// File: rtl/isa_busclk_gen.sv
// Bus clock generator: divides clk into a 50 percent duty bus clock.
// It also gives a one-cycle tick in the clock before each rising edge of the bus clock.
// Assumes: HALF_DIV >= 1.
module isa_busclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk,
    output logic tick
);
    localparam int PERIOD = 2 * HALF_DIV;
    localparam int CW     = $clog2(PERIOD);

    logic [CW-1:0] cnt;

    // Free-running phase counter over one bus clock period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == CW'(PERIOD - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == CW'(PERIOD - 1));
    assign bclk = (cnt < CW'(HALF_DIV));
endmodule

// File: rtl/isa_cmd_decode.sv
// Command strobe decoder: turns the kind of the held request into one active-low strobe.
// Output order: [3] memory read, [2] memory write, [1] IO read, [0] IO write.
// Assumes: cmd_on is high only during the command phase.
module isa_cmd_decode (
    input  logic       cmd_on,
    input  logic       wr,
    input  logic       io,
    output logic [3:0] strobe_n
);
    // One comparator per strobe, selected by {io, wr}.
    for (genvar i = 0; i < 4; i++) begin : g_strobe
        assign strobe_n[3-i] = ~(cmd_on && ({io, wr} == 2'(i)));
    end
endmodule

// File: rtl/isa_lane_steer.sv
// Byte lane steering for split and whole transfers.
// Write side: the whole word on the first transfer, the high byte moved to the low lanes on the second.
// Read side: works out the next value of the assembled read word when a capture happens.
// Assumes: `wide` is settled before the first capture of an access.
module isa_lane_steer #(
    parameter  int BYTE_W = 8,
    localparam int DW     = 2 * BYTE_W
) (
    input  logic [DW-1:0] wdata,
    input  logic          second,
    input  logic          wide,
    input  logic          capture,
    input  logic [DW-1:0] lanes_in,
    input  logic [DW-1:0] rd_cur,
    output logic [DW-1:0] lanes_out,
    output logic [DW-1:0] rd_next
);
    // Write lane selection: swap the high byte down on the second transfer.
    always_comb begin
        if (second) begin
            lanes_out = {{BYTE_W{1'b0}}, wdata[DW-1:BYTE_W]};
        end else begin
            lanes_out = wdata;
        end
    end

    // Read assembly: place the sampled lanes into the word being built.
    always_comb begin
        if (!capture) begin
            rd_next = rd_cur;
        end else if (second) begin
            rd_next = {lanes_in[BYTE_W-1:0], rd_cur[BYTE_W-1:0]};
        end else if (wide) begin
            rd_next = lanes_in;
        end else begin
            rd_next = {rd_cur[DW-1:BYTE_W], lanes_in[BYTE_W-1:0]};
        end
    end
endmodule

// File: rtl/isa_cycle_fsm.sv
// Transfer sequencer: holds one request and steps each transfer through the
// address, command and idle-gap phases on bus clock ticks. It splits the access
// when the target did not claim 16-bit width during the first address phase.
// Assumes: req is taken only in the idle phase; CMD_CLKS >= 1.
module isa_cycle_fsm
    import isa_sizer_pkg::*;
#(
    parameter  int ADDR_W   = 20,
    parameter  int BYTE_W   = 8,
    parameter  int CMD_CLKS = 3,
    localparam int DW       = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req,
    input  logic              req_wr,
    input  logic              req_io,
    input  logic [ADDR_W-2:0] req_waddr,
    input  logic [DW-1:0]     req_wdata,
    input  logic              wide_ack_n,
    input  logic [DW-1:0]     lanes_in,
    output logic              ale,
    output logic [ADDR_W-1:0] addr_out,
    output logic              hi_lane_n,
    output logic              cmd_on,
    output logic              drive_en,
    output logic              kind_wr,
    output logic              kind_io,
    output logic [DW-1:0]     lanes_out,
    output logic [DW-1:0]     rdata,
    output logic              done
);
    localparam int CCW = (CMD_CLKS > 1) ? $clog2(CMD_CLKS) : 1;

    phase_t            phase;
    logic              second;
    logic              wide;
    logic [CCW-1:0]    cnt;
    logic [ADDR_W-2:0] waddr_q;
    logic [DW-1:0]     wdata_q;
    logic              wr_q;
    logic              io_q;
    logic              last_cmd;
    logic              capture;
    logic [DW-1:0]     rd_next;

    assign last_cmd = (cnt == CCW'(CMD_CLKS - 1));
    assign capture  = (phase == PH_CMD) && tick && last_cmd && !wr_q;

    isa_lane_steer #(.BYTE_W(BYTE_W)) u_steer (
        .wdata     (wdata_q),
        .second    (second),
        .wide      (wide),
        .capture   (capture),
        .lanes_in  (lanes_in),
        .rd_cur    (rdata),
        .lanes_out (lanes_out),
        .rd_next   (rd_next)
    );

    // Phase sequencing, request capture, width sampling and read assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            second  <= 1'b0;
            wide    <= 1'b1;
            cnt     <= '0;
            waddr_q <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            io_q    <= 1'b0;
            rdata   <= '0;
            done    <= 1'b0;
        end else begin
            done  <= 1'b0;
            rdata <= rd_next;
            case (phase)
                PH_IDLE: begin
                    if (req) begin
                        waddr_q <= req_waddr;
                        wdata_q <= req_wdata;
                        wr_q    <= req_wr;
                        io_q    <= req_io;
                        second  <= 1'b0;
                        phase   <= PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (tick) begin
                        phase <= PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    if (tick) begin
                        if (!second) begin
                            wide <= !wide_ack_n;
                        end
                        cnt   <= '0;
                        phase <= PH_CMD;
                    end
                end
                PH_CMD: begin
                    if (tick) begin
                        if (last_cmd) begin
                            phase <= PH_GAP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_GAP: begin
                    if (tick) begin
                        if (!wide && !second) begin
                            second <= 1'b1;
                            phase  <= PH_ADDR;
                        end else begin
                            done  <= 1'b1;
                            phase <= PH_IDLE;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Bus-side outputs decoded from the current phase.
    always_comb begin
        ale       = (phase == PH_ADDR) && !second;
        addr_out  = {waddr_q, second};
        hi_lane_n = !(((phase == PH_ADDR) || (phase == PH_CMD) || (phase == PH_GAP)) && !second);
        cmd_on    = (phase == PH_CMD);
        drive_en  = (phase == PH_CMD) && wr_q;
        kind_wr   = wr_q;
        kind_io   = io_q;
    end
endmodule

// File: rtl/isa_sizer.sv
// Bus sizing cycle controller top. It joins the bus clock generator, the transfer
// sequencer and the strobe decoder. The address latch enable output is
// the internal latch pulse ORed with the hold acknowledge.
// Assumes: the target holds wide_ack_n steady through the first address phase.
module isa_sizer #(
    parameter  int ADDR_W   = 20,
    parameter  int BYTE_W   = 8,
    parameter  int CMD_CLKS = 3,
    parameter  int HALF_DIV = 2,
    localparam int DW       = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic              req_io,
    input  logic [ADDR_W-2:0] req_waddr,
    input  logic [DW-1:0]     req_wdata,
    output logic [DW-1:0]     rdata,
    output logic              done,
    output logic              bclk,
    output logic              addr_latch,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              hi_lane_n,
    output logic [DW-1:0]     lane_out,
    output logic              lane_oe,
    input  logic [DW-1:0]     lane_in,
    input  logic              wide_ack_n,
    input  logic              hold_ack,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n
);
    logic       tick;
    logic       ale;
    logic       cmd_on;
    logic       kind_wr;
    logic       kind_io;
    logic [3:0] strobe_n;

    isa_busclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .bclk  (bclk),
        .tick  (tick)
    );

    isa_cycle_fsm #(
        .ADDR_W   (ADDR_W),
        .BYTE_W   (BYTE_W),
        .CMD_CLKS (CMD_CLKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .req        (req),
        .req_wr     (req_wr),
        .req_io     (req_io),
        .req_waddr  (req_waddr),
        .req_wdata  (req_wdata),
        .wide_ack_n (wide_ack_n),
        .lanes_in   (lane_in),
        .ale        (ale),
        .addr_out   (bus_addr),
        .hi_lane_n  (hi_lane_n),
        .cmd_on     (cmd_on),
        .drive_en   (lane_oe),
        .kind_wr    (kind_wr),
        .kind_io    (kind_io),
        .lanes_out  (lane_out),
        .rdata      (rdata),
        .done       (done)
    );

    isa_cmd_decode u_dec (
        .cmd_on   (cmd_on),
        .wr       (kind_wr),
        .io       (kind_io),
        .strobe_n (strobe_n)
    );

    assign addr_latch = ale | hold_ack;
    assign mem_rd_n   = strobe_n[3];
    assign mem_wr_n   = strobe_n[2];
    assign io_rd_n    = strobe_n[1];
    assign io_wr_n    = strobe_n[0];
endmodule

// File: rtl/isa_sizer_chk.sv
// Protocol checker for the sizing controller, attached to the top by bind.
// Assumes: synchronous active-low reset; all checks are off while reset is low.
module isa_sizer_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              addr_latch,
    input logic              hold_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              hi_lane_n,
    input logic              lane_oe,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic              io_rd_n,
    input logic              io_wr_n
);
    logic cmd_low;
    assign cmd_low = !mem_rd_n || !mem_wr_n || !io_rd_n || !io_wr_n;

    // R8: the address is held across consecutive command-phase clocks.
    assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_low && $past(cmd_low)) |-> $stable(bus_addr));

    // R6: during a command, the high-lane enable is low exactly on the first transfer (address bit 0 clear).
    assert_hi_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_low |-> (hi_lane_n == bus_addr[0]));

    // R7: a grant forces the latch enable high.
    assert_latch_on_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> addr_latch);

    // R5: with no grant, the latch enable never appears on a second transfer.
    assert_no_latch_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_latch && !hold_ack) |-> !bus_addr[0]);

    // R9: at most one command strobe is active.
    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!mem_rd_n, !mem_wr_n, !io_rd_n, !io_wr_n}));

    // R3: the lane output enable appears only under a write strobe.
    assert_oe_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lane_oe |-> (!mem_wr_n || !io_wr_n));

    // R4: done lasts a single clock.
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind isa_sizer isa_sizer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .addr_latch (addr_latch),
    .hold_ack   (hold_ack),
    .bus_addr   (bus_addr),
    .hi_lane_n  (hi_lane_n),
    .lane_oe    (lane_oe),
    .mem_rd_n   (mem_rd_n),
    .mem_wr_n   (mem_wr_n),
    .io_rd_n    (io_rd_n),
    .io_wr_n    (io_wr_n)
);

// File: tb/isa_sizer_test.sv
// Sweep bench for the sizing controller: every space, direction and target width over several addresses.
module isa_sizer_test;
    localparam int ADDR_W   = 20;
    localparam int CMD_CLKS = 2;
    localparam int HALF_DIV = 1;
    localparam int STROBE_W = CMD_CLKS * 2 * HALF_DIV;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic              req_wr = 1'b0;
    logic              req_io = 1'b0;
    logic [ADDR_W-2:0] req_waddr = '0;
    logic [15:0]       req_wdata = '0;
    logic [15:0]       rdata;
    logic              done;
    logic              bclk;
    logic              addr_latch;
    logic [ADDR_W-1:0] bus_addr;
    logic              hi_lane_n;
    logic [15:0]       lane_out;
    logic              lane_oe;
    logic [15:0]       lane_in;
    logic              wide_ack_n;
    logic              hold_ack = 1'b0;
    logic              mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
    logic              dev16 = 1'b0;

    integer errors = 0;
    integer checks = 0;

    always #2.5 clk = ~clk;

    isa_sizer #(
        .ADDR_W(ADDR_W), .BYTE_W(8), .CMD_CLKS(CMD_CLKS), .HALF_DIV(HALF_DIV)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_io(req_io),
        .req_waddr(req_waddr), .req_wdata(req_wdata), .rdata(rdata), .done(done),
        .bclk(bclk), .addr_latch(addr_latch), .bus_addr(bus_addr), .hi_lane_n(hi_lane_n),
        .lane_out(lane_out), .lane_oe(lane_oe), .lane_in(lane_in), .wide_ack_n(wide_ack_n),
        .hold_ack(hold_ack), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n)
    );

    // Byte pattern that the target model returns for a byte address.
    function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
        return a[7:0] * 8'd29 + a[15:8] + 8'd7;
    endfunction

    // Target model: answers wide or byte-wide; a byte target puts junk on the upper lanes.
    assign wide_ack_n = ~dev16;
    assign lane_in = (!mem_rd_n || !io_rd_n)
        ? (dev16 ? {pat(bus_addr | 1), pat(bus_addr & ~20'd1)} : {8'hA5, pat(bus_addr)})
        : 16'h0000;

    // Transfer monitor sampled at falling edges.
    logic [3:0]        t_kind [0:3];
    logic [ADDR_W-1:0] t_addr [0:3];
    logic              t_hi   [0:3];
    logic [15:0]       t_data [0:3];
    logic              t_oe   [0:3];
    integer            t_wid  [0:3];
    logic              t_stab [0:3];
    integer            n_xfer = 0;
    integer            latch_rise = 0;
    logic              prev_low = 1'b0;
    logic              prev_latch = 1'b0;

    always @(negedge clk) begin
        logic [3:0] cur;
        cur = {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};
        if (cur != 4'hF && !prev_low) begin
            if (n_xfer < 4) begin
                t_kind[n_xfer] = cur;
                t_addr[n_xfer] = bus_addr;
                t_hi[n_xfer]   = hi_lane_n;
                t_data[n_xfer] = lane_out;
                t_oe[n_xfer]   = lane_oe;
                t_wid[n_xfer]  = 1;
                t_stab[n_xfer] = 1'b1;
            end
            n_xfer = n_xfer + 1;
        end else if (cur != 4'hF && n_xfer > 0 && n_xfer <= 4) begin
            t_wid[n_xfer-1] = t_wid[n_xfer-1] + 1;
            if (bus_addr != t_addr[n_xfer-1]) t_stab[n_xfer-1] = 1'b0;
        end
        if (addr_latch && !prev_latch) latch_rise = latch_rise + 1;
        prev_low   = (cur != 4'hF);
        prev_latch = addr_latch;
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One access plus every per-transfer check against values worked out from the requirements.
    task automatic do_access(input logic [ADDR_W-2:0] wa, input logic wr, input logic io, input logic wide);
        logic [15:0]       wd;
        logic [ADDR_W-1:0] base;
        logic [3:0]        kind;
        logic [15:0]       exp_rd;
        integer            nx;
        integer            waited;
        wd   = {wa[7:0] ^ 8'h5A, wa[15:8] + 8'h33};
        base = {wa, 1'b0};
        case ({io, wr})
            2'b00: kind = 4'b0111;
            2'b01: kind = 4'b1011;
            2'b10: kind = 4'b1101;
            default: kind = 4'b1110;
        endcase
        exp_rd = {pat(base | 1), pat(base)};
        nx = wide ? 1 : 2;
        @(negedge clk);
        n_xfer = 0;
        latch_rise = 0;
        dev16 = wide;
        req_waddr = wa; req_wr = wr; req_io = io; req_wdata = wd; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        waited = 0;
        while (!done && waited < 400) begin
            @(negedge clk);
            waited = waited + 1;
        end
        check(done, "R4 done seen", {31'd0, done}, 1);
        @(negedge clk);
        check(!done, "R4 done single clock", {31'd0, done}, 0);
        check(n_xfer == nx, "R1 transfer count", n_xfer, nx);
        check(latch_rise == 1, "R5 latch pulses per access", latch_rise, 1);
        for (int k = 0; k < 2; k++) begin
            if (k < nx && k < n_xfer) begin
                check(t_addr[k] == (base | ADDR_W'(k)), "R2 transfer address", t_addr[k], base | ADDR_W'(k));
                check(t_hi[k] == (k == 1), "R6 high lane enable", {31'd0, t_hi[k]}, (k == 1));
                check(t_kind[k] == kind, "R9 strobe select", {28'd0, t_kind[k]}, {28'd0, kind});
                check(t_wid[k] == STROBE_W, "R10 strobe width", t_wid[k], STROBE_W);
                check(t_stab[k], "R8 address stable", {31'd0, t_stab[k]}, 1);
                if (wr) begin
                    check(t_oe[k], "R3 lane enable", {31'd0, t_oe[k]}, 1);
                    check(t_data[k] == ((k == 0) ? wd : {8'h00, wd[15:8]}), "R3 write lanes",
                          t_data[k], (k == 0) ? wd : {8'h00, wd[15:8]});
                end else begin
                    check(!t_oe[k], "R3 no lane enable on read", {31'd0, t_oe[k]}, 0);
                end
            end
        end
        if (!wr) check(rdata == exp_rd, "R4 read word", rdata, exp_rd);
    endtask

    initial begin
        logic [ADDR_W-2:0] addrs [0:3];
        logic              last;
        integer            toggles;
        addrs[0] = 19'h00008; addrs[1] = 19'h0051F; addrs[2] = 19'h7AAA9; addrs[3] = 19'h3FFFF;
        repeat (4) @(negedge clk);
        check({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n} == 4'hF, "R9 strobes idle in reset",
              {28'd0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 32'hF);
        check(!done && !lane_oe && !addr_latch, "R5 reset outputs quiet",
              {29'd0, done, lane_oe, addr_latch}, 0);
        check(hi_lane_n, "R6 high lane idle in reset", {31'd0, hi_lane_n}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        last = bclk; toggles = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (bclk != last) toggles = toggles + 1;
            last = bclk;
        end
        check(toggles == 8, "R10 bus clock duty", toggles, 8);
        for (int a = 0; a < 4; a++)
            for (int m = 0; m < 8; m++)
                do_access(addrs[a], m[0], m[1], m[2]);
        @(negedge clk);
        hold_ack = 1'b1;
        @(negedge clk);
        check(addr_latch, "R7 latch high under grant", {31'd0, addr_latch}, 1);
        repeat (3) @(negedge clk);
        check(addr_latch, "R7 latch held under grant", {31'd0, addr_latch}, 1);
        hold_ack = 1'b0;
        @(negedge clk);
        check(!addr_latch, "R7 latch low after grant", {31'd0, addr_latch}, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule